// File: doc/BRIEF.md
# Mailbox Interrupt Flags for a Two-Port Shared Memory

This block generates one interrupt line for each side of a two-port shared memory. The two highest word addresses act as mailboxes. The topmost word belongs to the right port and the word just below it belongs to the left port. When one port writes into its peer's mailbox, the peer's interrupt is raised. When the owning port reads its own mailbox, that interrupt is dropped. The message itself sits in the ordinary memory array. This block only watches the address and control of each access and keeps the two flags.

Each port gives this block the same access strobes it gives the memory: an enable, a write select, an output enable, the word address and the busy flag from the contention arbiter. A port that is being held off by the arbiter cannot raise its peer's flag. It also cannot clear its own flag. The strobes are sampled on the rising clock edge. A flag changes state on the edge that samples the access that causes the change. There is no data stream at the edge of this block, so every pin is a plain level.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, both `l_int_n` and `r_int_n` are high (inactive).
- R2: A left write (`l_en`=1, `l_wr`=1, `l_busy`=0) to address all-ones drives `r_int_n` low from the next clock edge.
- R3: A right write (`r_en`=1, `r_wr`=1, `r_busy`=0) to address all-ones-minus-one drives `l_int_n` low from the next clock edge.
- R4: An owner read (`en`=1, `wr`=0, `oe`=1, busy=0) clears the owner's flag on the next edge. For the right port the read is of all-ones, and `r_int_n` returns high. For the left port the read is of all-ones-minus-one, and `l_int_n` returns high.
- R5: A port that reads its peer's mailbox changes neither interrupt line.
- R6: While a port's busy input is 1, its write to the peer mailbox leaves the peer's interrupt line unchanged.
- R7: While a port's busy input is 1, its read of its own mailbox leaves its own interrupt line unchanged.
- R8: If a flag receives a valid set and a valid clear on the same edge, the flag ends up set (line low).
- R9: The following accesses leave both lines unchanged: any access with enable 0, a read with output enable 0, a write by a port to its own mailbox, and any access to another address.
- R10: With no set or clear, each interrupt line keeps its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left port access enable, active high |
| l_wr | input | 1 | Left port write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable, active high |
| l_addr | input | ADDR_W | Left port word address |
| l_busy | input | 1 | Left port held off by arbiter, active high |
| r_en | input | 1 | Right port access enable, active high |
| r_wr | input | 1 | Right port write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable, active high |
| r_addr | input | ADDR_W | Right port word address |
| r_busy | input | 1 | Right port held off by arbiter, active high |
| l_int_n | output | 1 | Left port interrupt, active low |
| r_int_n | output | 1 | Right port interrupt, active low |

## Verification
Some rules are checked by the assertions on every cycle. A valid peer write always pulls the peer line low on the next edge, even when a clear arrives on the same edge. An unblocked owner read with no competing set always releases the line. A line may fall only after a valid unblocked set, and it may rise only after a valid unblocked clear. Only the bench's sweeps can show other things: that every other address and strobe combination is truly inert, how mixed traffic on both ports builds up over many cycles, and how the flags behave around reset. The sweeps cover every combination of both ports' strobes and addresses on a small address width.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  // Port index used for the per-port generate structures.
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Decoded mailbox requests produced by one port.
  typedef struct packed {
    logic post_peer;  // unblocked write into the peer's mailbox
    logic take_own;   // unblocked read of this port's own mailbox
  } mbx_req_t;

  // Strobes of one port, gathered for the decoder.
  typedef struct packed {
    logic en;
    logic wr;
    logic oe;
    logic busy;
  } port_ctl_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit OWN_TOP = 1'b0  // 1: this port owns the highest word
) (
  input  port_ctl_t          ctl,
  input  logic [ADDR_W-1:0]  addr,
  output mbx_req_t           req
);

  localparam logic [ADDR_W-1:0] TOP_WORD  = '1;
  localparam logic [ADDR_W-1:0] NEXT_WORD = TOP_WORD - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OWN_BOX   = OWN_TOP ? TOP_WORD : NEXT_WORD;
  localparam logic [ADDR_W-1:0] PEER_BOX  = OWN_TOP ? NEXT_WORD : TOP_WORD;

  logic hit_own;
  logic hit_peer;
  logic is_write;
  logic is_read;

  always_comb begin
    hit_own  = (addr == OWN_BOX);
    hit_peer = (addr == PEER_BOX);
    is_write = ctl.en &  ctl.wr;
    is_read  = ctl.en & ~ctl.wr & ctl.oe;
    req.post_peer = is_write & hit_peer & ~ctl.busy;
    req.take_own  = is_read  & hit_own  & ~ctl.busy;
  end

endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;

  // A set on the same edge as a clear takes precedence.
  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy,
  output logic              l_int_n,
  output logic              r_int_n
);

  localparam int NUM_SIDES = 2;

  port_ctl_t         ctl  [NUM_SIDES];
  logic [ADDR_W-1:0] addr [NUM_SIDES];
  mbx_req_t          req  [NUM_SIDES];
  logic              flag [NUM_SIDES];

  always_comb begin
    ctl[SIDE_LEFT]   = '{en: l_en, wr: l_wr, oe: l_oe, busy: l_busy};
    ctl[SIDE_RIGHT]  = '{en: r_en, wr: r_wr, oe: r_oe, busy: r_busy};
    addr[SIDE_LEFT]  = l_addr;
    addr[SIDE_RIGHT] = r_addr;
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    // The right side owns the highest word, the left side the one below.
    mbx_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_TOP (s == int'(SIDE_RIGHT))
    ) u_dec (
      .ctl  (ctl[s]),
      .addr (addr[s]),
      .req  (req[s])
    );

    // A side's flag is posted by the opposite side and taken by itself.
    mbx_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req[NUM_SIDES-1-s].post_peer),
      .clr_i  (req[s].take_own),
      .flag_o (flag[s])
    );
  end

  assign l_int_n = ~flag[SIDE_LEFT];
  assign r_int_n = ~flag[SIDE_RIGHT];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic              l_wr,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy,
  input logic              r_en,
  input logic              r_wr,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy,
  input logic              l_int_n,
  input logic              r_int_n
);

  localparam logic [ADDR_W-1:0] HI = '1;
  localparam logic [ADDR_W-1:0] LO = HI - ADDR_W'(1);

  logic set_r, clr_r, set_l, clr_l;
  logic try_set_r, try_clr_r, try_set_l, try_clr_l;

  assign try_set_r = l_en && l_wr && (l_addr == HI);
  assign try_clr_r = r_en && !r_wr && r_oe && (r_addr == HI);
  assign try_set_l = r_en && r_wr && (r_addr == LO);
  assign try_clr_l = l_en && !l_wr && l_oe && (l_addr == LO);
  assign set_r = try_set_r && !l_busy;
  assign clr_r = try_clr_r && !r_busy;
  assign set_l = try_set_l && !r_busy;
  assign clr_l = try_clr_l && !l_busy;

  p_set_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_r |=> !r_int_n);
  p_set_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_l |=> !l_int_n);
  p_clear_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r && !set_r) |=> r_int_n);
  p_clear_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l && !set_l) |=> l_int_n);
  p_fall_needs_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_int_n) |-> $past(set_r));
  p_fall_left_needs_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_int_n) |-> $past(set_l));
  p_rise_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_int_n) |-> $past(clr_r));
  p_rise_left_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_int_n) |-> $past(clr_l));
  p_both_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_r && clr_r) |=> !r_int_n);
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_r && !clr_r && !set_l && !clr_l) |=> ($stable(r_int_n) && $stable(l_int_n)));

endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_mbx_irq_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
  .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
  .l_int_n(l_int_n), .r_int_n(r_int_n)
);

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;

  localparam int AW   = 3;
  localparam int HI   = (1 << AW) - 1;
  localparam int LO   = HI - 1;
  localparam int NCMB = 1 << (2 * (4 + AW));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_wr = 0, l_oe = 0, l_busy = 0;
  logic r_en = 0, r_wr = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_int_n, r_int_n;

  int checks = 0;
  int errors = 0;
  bit exp_l = 1'b0;  // expected flag state (1 = interrupt pending)
  bit exp_r = 1'b0;

  always #4 clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) i_mbx_irq_top (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
    .l_int_n(l_int_n), .r_int_n(r_int_n)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Apply one access pair, predict both flags and check after the edge.
  task automatic step(bit len, bit lwr, bit loe, bit lbz, int la,
                      bit ren, bit rwr, bit roe, bit rbz, int ra);
    bit s_r, c_r, s_l, c_l, ts_r, tc_r, ts_l, tc_l;
    string tag_r, tag_l;
    @(negedge clk);
    l_en = len; l_wr = lwr; l_oe = loe; l_busy = lbz; l_addr = AW'(la);
    r_en = ren; r_wr = rwr; r_oe = roe; r_busy = rbz; r_addr = AW'(ra);
    ts_r = len && lwr && la == HI;
    tc_r = ren && !rwr && roe && ra == HI;
    ts_l = ren && rwr && ra == LO;
    tc_l = len && !lwr && loe && la == LO;
    s_r = ts_r && !lbz; c_r = tc_r && !rbz;
    s_l = ts_l && !rbz; c_l = tc_l && !lbz;
    if (s_r && c_r)      tag_r = "R8";
    else if (s_r)        tag_r = "R2";
    else if (c_r)        tag_r = "R4";
    else if (ts_r)       tag_r = "R6";
    else if (tc_r)       tag_r = "R7";
    else if (ren && !rwr && roe && ra == LO) tag_r = "R5";
    else if (len || ren) tag_r = "R9";
    else                 tag_r = "R10";
    if (s_l && c_l)      tag_l = "R8";
    else if (s_l)        tag_l = "R3";
    else if (c_l)        tag_l = "R4";
    else if (ts_l)       tag_l = "R6";
    else if (tc_l)       tag_l = "R7";
    else if (len && !lwr && loe && la == HI) tag_l = "R5";
    else if (len || ren) tag_l = "R9";
    else                 tag_l = "R10";
    exp_r = s_r | (exp_r & ~c_r);
    exp_l = s_l | (exp_l & ~c_l);
    @(posedge clk);
    #1;
    check({tag_r, " right"}, r_int_n, ~exp_r);
    check({tag_l, " left"},  l_int_n, ~exp_l);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : stim
    // R1: lines inactive during reset and right after release.
    repeat (3) @(posedge clk);
    #1;
    check("R1 right in reset", r_int_n, 1'b1);
    check("R1 left in reset",  l_int_n, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 right after reset", r_int_n, 1'b1);
    check("R1 left after reset",  l_int_n, 1'b1);

    // Directed: post, peek at peer box, blocked clear, real clear.
    step(1,1,0,0,HI, 0,0,0,0,0);   // R2 left posts to right
    step(0,0,0,0,0,  1,1,0,0,LO);  // R3 right posts to left
    step(1,0,1,0,HI, 1,0,1,0,LO);  // R5 both read peer box
    step(0,0,0,0,0,  1,0,1,1,HI);  // R7 blocked owner read
    step(1,1,0,1,HI, 0,0,0,0,0);   // R6 blocked post
    step(0,0,0,0,0,  1,0,1,0,HI);  // R4 right clears
    step(1,0,1,0,LO, 0,0,0,0,0);   // R4 left clears
    step(1,1,0,0,HI, 1,0,1,0,HI);  // R8 set and clear together
    step(0,0,0,0,0,  0,0,0,0,0);   // R10 hold

    // Exhaustive sweep of all strobe and address pairs, scrambled order.
    for (int i = 0; i < NCMB; i++) begin
      int v;
      v = (i * 40503) % NCMB;
      step(v[0], v[1], v[2], v[3], (v >> 4) % (1 << AW),
           v[7], v[8], v[9], v[10], (v >> 11) % (1 << AW));
    end

    // R1: reset mid-run drops pending flags.
    step(1,1,0,0,HI, 1,1,0,0,LO);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 right async reset", r_int_n, 1'b1);
    check("R1 left async reset",  l_int_n, 1'b1);
    finish_run();
  end

endmodule